// File: doc/BRIEF.md
# Arbiter Delay Race Emulator

This block is a cycle-based digital model of a delay-race identification circuit. It is meant for a secure processor. A row of switch stages carries two racing signals. Each stage either passes the two signals through unchanged or swaps them, and the bit of the challenge word at that stage's index makes the choice. Every stage stores two device-specific delay values, one for the straight lane and one for the crossed lane. A load port fills these values, which stand in for the random spread of a real fabrication run. When the race ends, an arbiter turns the sign of the difference in arrival time into one response bit.

A start pulse launches one race and the block then walks the stages one per clock. To build a response of several bits, the block runs several races back to back. The first race uses the supplied challenge, and each following race uses the next state of a shift register with linear feedback. The whole response appears at once, together with a one-cycle valid pulse. The result stays on the output until the next evaluation completes. The output has no back-pressure: a consumer must capture the value while it is held, and no handshake is needed for that.

Top module: `arb_puf_emu`

## Requirements
- R1: After reset `busy`, `resp_valid` and `resp` are all 0, and every stored delay is 0.
- R2: A race starts with both lanes at delay 0. At stage i (i = 0 to STAGES-1), if challenge bit i is 0, the upper lane adds the stage's straight delay and the lower lane adds its crossed delay.
- R3: If challenge bit i is 1, the two signals swap. The new upper value is the old lower value plus the crossed delay, and the new lower value is the old upper value plus the straight delay.
- R4: A response bit is 1 only when the final upper delay is strictly less than the final lower delay. A tie gives 0.
- R5: If `start` is accepted at clock edge k, `resp_valid` is high for exactly one cycle, after edge k + STAGES*(resp_len_m1+1). `busy` is high from edge k until that same edge.
- R6: `start` has no effect while `busy` is high. The running evaluation keeps its challenge, length and timing.
- R7: `resp_len_m1` asks for L = resp_len_m1+1 bits. Race j (counting from 0) lands in `resp[L-1-j]`, and every bit above L-1 is 0. Race 0 uses `chal`. Each later challenge c becomes {c[STAGES-2:0], c[15]^c[13]^c[12]^c[10]}; these tap positions are for STAGES=16, and in general they are STAGES-1, -3, -4 and -6.
- R8: A write with `ld_en` high sets the delay of stage `ld_stage`. The straight delay is set when `ld_lane` is 0 and the crossed delay when it is 1. Evaluations started after the write use the new value.
- R9: `resp` changes only in a cycle where `resp_valid` is high, and it is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted when not busy |
| chal | input | STAGES | Challenge word, bit i steers stage i |
| resp_len_m1 | input | clog2(RMAX) | Requested response length minus one |
| ld_en | input | 1 | Delay table write strobe |
| ld_stage | input | clog2(STAGES) | Stage index to write |
| ld_lane | input | 1 | 0 = straight delay, 1 = crossed delay |
| ld_delay | input | DW | Delay value to write |
| busy | output | 1 | Evaluation in progress |
| resp | output | RMAX | Response bits, held between completions |
| resp_valid | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after tied races. A comparator that gets the tie rule wrong reports 1 when it should report 0. It tests challenges that are all-straight and all-crossed, which expose lanes mixed up at a swap or a crossed delay added to the wrong signal. A start pulse arrives in the middle of a run: a design that fails to ignore it restarts, takes a new challenge or fires a second completion pulse. Random multi-bit runs with random delay tables expose a wrong feedback tap, bits placed in reverse order, garbage bits above the requested length and completion pulses that come a cycle off.

// File: rtl/apuf_pkg.sv
package apuf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RACE = 1'b1
  } race_state_e;

  localparam logic LANE_STRAIGHT = 1'b0;
  localparam logic LANE_CROSSED  = 1'b1;
endpackage

// File: rtl/apuf_delay_table.sv
module apuf_delay_table #(
  parameter int STAGES = 16,
  parameter int DW     = 8,
  localparam int SW    = $clog2(STAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_stage,
  input  logic          wr_lane,
  input  logic [DW-1:0] wr_val,
  input  logic [SW-1:0] rd_stage,
  output logic [DW-1:0] rd_straight,
  output logic [DW-1:0] rd_crossed
);
  import apuf_pkg::*;

  logic [DW-1:0] str_q [STAGES];
  logic [DW-1:0] crs_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        str_q[g] <= '0;
        crs_q[g] <= '0;
      end else if (wr_en && wr_stage == SW'(g)) begin
        if (wr_lane == LANE_STRAIGHT) str_q[g] <= wr_val;
        else                          crs_q[g] <= wr_val;
      end
    end
  end

  assign rd_straight = str_q[rd_stage];
  assign rd_crossed  = crs_q[rd_stage];
endmodule

// File: rtl/apuf_switch_step.sv
module apuf_switch_step #(
  parameter int DW = 8,
  parameter int AW = 13
) (
  input  logic [AW-1:0] up_in,
  input  logic [AW-1:0] lo_in,
  input  logic          swap,
  input  logic [DW-1:0] d_straight,
  input  logic [DW-1:0] d_crossed,
  output logic [AW-1:0] up_out,
  output logic [AW-1:0] lo_out
);
  always_comb begin
    if (swap) begin
      up_out = lo_in + AW'(d_crossed);
      lo_out = up_in + AW'(d_straight);
    end else begin
      up_out = up_in + AW'(d_straight);
      lo_out = lo_in + AW'(d_crossed);
    end
  end
endmodule

// File: rtl/apuf_arbiter.sv
module apuf_arbiter #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] up_arrival,
  input  logic [AW-1:0] lo_arrival,
  output logic          up_wins
);
  assign up_wins = (up_arrival < lo_arrival);
endmodule

// File: rtl/arb_puf_emu.sv
module arb_puf_emu #(
  parameter int STAGES = 16,
  parameter int DW     = 8,
  parameter int RMAX   = 8,
  localparam int SW    = $clog2(STAGES),
  localparam int LW    = $clog2(RMAX),
  localparam int AW    = DW + SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STAGES-1:0] chal,
  input  logic [LW-1:0]     resp_len_m1,
  input  logic              ld_en,
  input  logic [SW-1:0]     ld_stage,
  input  logic              ld_lane,
  input  logic [DW-1:0]     ld_delay,
  output logic              busy,
  output logic [RMAX-1:0]   resp,
  output logic              resp_valid
);
  import apuf_pkg::*;

  race_state_e       state_q;
  logic [STAGES-1:0] cur_chal_q;
  logic [SW-1:0]     stage_q;
  logic [LW-1:0]     bit_q;
  logic [LW-1:0]     len_q;
  logic [AW-1:0]     up_q, lo_q, up_n, lo_n;
  logic [RMAX-1:0]   shreg_q, shreg_n;
  logic [DW-1:0]     d_str, d_crs;
  logic              win;
  logic              last_stage, last_bit, fb;

  apuf_delay_table #(.STAGES(STAGES), .DW(DW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ld_en),
    .wr_stage   (ld_stage),
    .wr_lane    (ld_lane),
    .wr_val     (ld_delay),
    .rd_stage   (stage_q),
    .rd_straight(d_str),
    .rd_crossed (d_crs)
  );

  apuf_switch_step #(.DW(DW), .AW(AW)) u_step (
    .up_in     (up_q),
    .lo_in     (lo_q),
    .swap      (cur_chal_q[stage_q]),
    .d_straight(d_str),
    .d_crossed (d_crs),
    .up_out    (up_n),
    .lo_out    (lo_n)
  );

  apuf_arbiter #(.AW(AW)) u_arb (
    .up_arrival(up_n),
    .lo_arrival(lo_n),
    .up_wins   (win)
  );

  assign last_stage = (stage_q == SW'(STAGES - 1));
  assign last_bit   = (bit_q == len_q);
  assign shreg_n    = {shreg_q[RMAX-2:0], win};
  assign fb         = cur_chal_q[STAGES-1] ^ cur_chal_q[STAGES-3]
                    ^ cur_chal_q[STAGES-4] ^ cur_chal_q[STAGES-6];
  assign busy       = (state_q == ST_RACE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_chal_q <= '0;
      stage_q    <= '0;
      bit_q      <= '0;
      len_q      <= '0;
      up_q       <= '0;
      lo_q       <= '0;
      shreg_q    <= '0;
      resp       <= '0;
      resp_valid <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q    <= ST_RACE;
            cur_chal_q <= chal;
            len_q      <= resp_len_m1;
            stage_q    <= '0;
            bit_q      <= '0;
            up_q       <= '0;
            lo_q       <= '0;
            shreg_q    <= '0;
          end
        end
        ST_RACE: begin
          if (!last_stage) begin
            stage_q <= stage_q + 1'b1;
            up_q    <= up_n;
            lo_q    <= lo_n;
          end else begin
            stage_q <= '0;
            up_q    <= '0;
            lo_q    <= '0;
            shreg_q <= shreg_n;
            if (last_bit) begin
              state_q    <= ST_IDLE;
              resp       <= shreg_n;
              resp_valid <= 1'b1;
            end else begin
              bit_q      <= bit_q + 1'b1;
              cur_chal_q <= {cur_chal_q[STAGES-2:0], fb};
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arb_puf_emu_chk.sv
module arb_puf_emu_chk #(
  parameter int STAGES = 16,
  parameter int RMAX   = 8,
  localparam int LW    = $clog2(RMAX)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [LW-1:0]   resp_len_m1,
  input logic            busy,
  input logic [RMAX-1:0] resp,
  input logic            resp_valid
);
  logic [31:0]   cyc_q;
  logic [LW-1:0] len_q;
  logic [31:0]   expect_cyc;
  logic [RMAX:0] hi_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q <= '0;
      len_q <= '0;
    end else if (start && !busy) begin
      cyc_q <= 32'd1;
      len_q <= resp_len_m1;
    end else if (busy) begin
      cyc_q <= cyc_q + 32'd1;
    end
  end

  assign expect_cyc = 32'(STAGES) * (32'(len_q) + 32'd1) + 32'd1;
  assign hi_mask    = ~((RMAX+1)'(1) << (32'(len_q) + 32'd1)) + (RMAX+1)'(1);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R5
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (cyc_q == expect_cyc));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> resp_valid);

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> $stable(resp));

  // R7
  resp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (({1'b0, resp} & hi_mask) == '0));
endmodule

bind arb_puf_emu arb_puf_emu_chk #(.STAGES(STAGES), .RMAX(RMAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .resp_len_m1(resp_len_m1),
  .busy       (busy),
  .resp       (resp),
  .resp_valid (resp_valid)
);

// File: tb/arb_puf_emu_test.sv
module arb_puf_emu_test;
  localparam int STAGES = 16;
  localparam int DW     = 8;
  localparam int RMAX   = 8;
  localparam int SW     = $clog2(STAGES);
  localparam int LW     = $clog2(RMAX);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [STAGES-1:0] chal = '0;
  logic [LW-1:0]     resp_len_m1 = '0;
  logic              ld_en = 1'b0;
  logic [SW-1:0]     ld_stage = '0;
  logic              ld_lane = 1'b0;
  logic [DW-1:0]     ld_delay = '0;
  logic              busy;
  logic [RMAX-1:0]   resp;
  logic              resp_valid;

  int checks = 0;
  int errors = 0;
  int tb_str [STAGES];
  int tb_crs [STAGES];

  arb_puf_emu #(.STAGES(STAGES), .DW(DW), .RMAX(RMAX)) uut (.*);

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [STAGES-1:0] next_chal(input logic [STAGES-1:0] c);
    return {c[STAGES-2:0], c[15] ^ c[13] ^ c[12] ^ c[10]};
  endfunction

  function automatic int model(input logic [STAGES-1:0] c0, input int lm1);
    logic [STAGES-1:0] c = c0;
    int r = 0;
    for (int e = 0; e <= lm1; e++) begin
      int a = 0;
      int b = 0;
      for (int i = 0; i < STAGES; i++) begin
        int na, nb;
        if (c[i]) begin na = b + tb_crs[i]; nb = a + tb_str[i]; end
        else      begin na = a + tb_str[i]; nb = b + tb_crs[i]; end
        a = na;
        b = nb;
      end
      r = (r << 1) | ((a < b) ? 1 : 0);
      c = next_chal(c);
    end
    return r;
  endfunction

  task automatic load(input int stg, input int lane, input int val);
    ld_en = 1'b1; ld_stage = SW'(stg); ld_lane = lane[0]; ld_delay = DW'(val);
    tick();
    ld_en = 1'b0;
    if (lane == 0) tb_str[stg] = val; else tb_crs[stg] = val;
  endtask

  task automatic load_all(input int s, input int x);
    for (int i = 0; i < STAGES; i++) begin
      load(i, 0, s);
      load(i, 1, x);
    end
  endtask

  task automatic run(input logic [STAGES-1:0] c, input int lm1, output int lat);
    chal = c; resp_len_m1 = LW'(lm1); start = 1'b1;
    tick();
    start = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 1000) begin
      tick();
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    logic [RMAX-1:0] held;
    logic [STAGES-1:0] c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < STAGES; i++) begin tb_str[i] = 0; tb_crs[i] = 0; end
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 resp_valid", resp_valid, 0);
    check("R1 resp", resp, 0);

    // R1/R4: cleared table gives a tie, so 0
    run(16'hA5C3, 0, lat);
    check("R4 tie on reset table", resp, 0);
    check("R5 latency one bit", lat, STAGES);
    tick();
    check("R5 pulse width", resp_valid, 0);

    // R2: all straight, straight=1 crossed=2 -> upper 16, lower 32 -> 1
    load_all(1, 2);
    run(16'h0000, 0, lat);
    check("R2 straight path", resp, 1);
    // R8: change stage 3 straight delay to 100 -> upper 115 > 32 -> 0
    load(3, 0, 100);
    run(16'h0000, 0, lat);
    check("R8 table write effect", resp, 0);

    // R3: all crossed
    load_all(2, 1);
    run(16'hFFFF, 0, lat);
    check("R3 crossed path", resp, model(16'hFFFF, 0));
    load(5, 1, 9);
    run(16'hFFFF, 0, lat);
    check("R3 crossed asymmetric", resp, model(16'hFFFF, 0));

    // R4: equal delays everywhere -> tie -> 0 for any challenge
    load_all(7, 7);
    run(16'h3C5A, 3, lat);
    check("R4 tie multi-bit", resp, 0);

    // R6: start while busy is ignored
    for (int i = 0; i < STAGES; i++) begin
      load(i, 0, int'($urandom_range(0, 255)));
      load(i, 1, int'($urandom_range(0, 255)));
    end
    chal = 16'h1234; resp_len_m1 = LW'(1); start = 1'b1;
    tick();
    start = 1'b0;
    lat = 0;
    repeat (5) begin tick(); lat++; end
    chal = 16'hBEEF; resp_len_m1 = LW'(6); start = 1'b1;
    tick(); lat++;
    start = 1'b0;
    while (!resp_valid && lat < 1000) begin tick(); lat++; end
    check("R6 latency unchanged", lat, 2 * STAGES);
    check("R6 result unchanged", resp, model(16'h1234, 1));

    // R9: held after the pulse
    held = resp;
    repeat (10) tick();
    check("R9 resp held", resp, held);
    check("R9 no extra pulse", resp_valid, 0);

    // R7/R5: random tables, challenges and lengths
    for (int t = 0; t < 40; t++) begin
      int lm1;
      if (t % 8 == 0) begin
        for (int i = 0; i < STAGES; i++) begin
          load(i, 0, int'($urandom_range(0, 255)));
          load(i, 1, int'($urandom_range(0, 255)));
        end
      end
      c = STAGES'($urandom());
      lm1 = int'($urandom_range(0, RMAX - 1));
      run(c, lm1, lat);
      check("R7 random response", resp, model(c, lm1));
      check("R5 random latency", lat, STAGES * (lm1 + 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule